// File: doc/BRIEF.md
# Color-Range Segmentation and Detection

This block sits in a streaming video path and works on one 24-bit RGB pixel per clock, framed by valid, start-of-frame, end-of-line and end-of-frame markers. For each pixel it keeps only the top four bits of the red, green and blue bytes. It then tests each of those nibbles against a programmable inclusive window, one window per channel. A pixel is a hit only when all three channels fall inside their windows.

The output stream is the input stream two cycles later. A view-select input, normally tied to a board switch, picks what the output carries. In pass view it carries the camera pixels unchanged. In mask view it carries a highlight color for hits and black for everything else. The framing markers travel through the same two register stages, so they stay aligned with the pixel data.

Alongside the video, a counter tallies the hits in each frame. When the last pixel of a frame goes by, the block compares the total with a programmable threshold. It then latches the total and an object-present flag, and pulses a done strobe for one cycle. The latched values hold until the next frame ends. The counter is wide enough for 1600 x 1200 frames.

Top module: `colseg_detect`

## Requirements
- R1: Only bits [7:4] of each 8-bit channel take part in the range test. Bits [3:0] never change whether a pixel is a hit.
- R2: A pixel is a hit when, for red (in_rgb[23:16]), green (in_rgb[15:8]) and blue (in_rgb[7:0]), lo <= nibble <= hi holds for every channel, with both bounds inclusive. A window whose lo is greater than its hi matches nothing.
- R3: When mask_view is 0, every output pixel with out_valid high equals the input pixel accepted two clock cycles earlier.
- R4: When mask_view is 1, an output pixel with out_valid high is HILITE (default 24'hFFFFFF) for a hit and 24'h000000 otherwise.
- R5: out_valid, out_sof, out_eol and out_eof equal in_valid, in_sof, in_eol and in_eof from two cycles earlier.
- R6: The hit count restarts with the pixel that carries in_sof. Only cycles with in_valid high are counted, whatever data is on in_rgb during idle cycles.
- R7: det_done rises for one cycle together with out_eof for a frame's last pixel. In that cycle det_count holds the frame's hit total, including the last pixel, and det_flag is 1 exactly when det_count >= threshold.
- R8: det_flag and det_count keep their values in every cycle in which det_done is low.
- R9: After reset, out_valid, det_done, det_flag and det_count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_eof | input | 1 | Last pixel of a frame |
| in_rgb | input | 24 | Input pixel, red in the top byte |
| mask_view | input | 1 | 0 = pass video, 1 = mask view |
| r_lo | input | 4 | Red window lower bound |
| r_hi | input | 4 | Red window upper bound |
| g_lo | input | 4 | Green window lower bound |
| g_hi | input | 4 | Green window upper bound |
| b_lo | input | 4 | Blue window lower bound |
| b_hi | input | 4 | Blue window upper bound |
| threshold | input | 21 | Hit count needed to declare detection |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Delayed start-of-frame |
| out_eol | output | 1 | Delayed end-of-line |
| out_eof | output | 1 | Delayed end-of-frame |
| out_rgb | output | 24 | Output pixel |
| det_flag | output | 1 | Object present in the last finished frame |
| det_count | output | 21 | Hit total of the last finished frame |
| det_done | output | 1 | One-cycle strobe when a frame result is latched |

## Verification
The bench aims at the window edges. It drives nibbles equal to lo and to hi with both all-zero and all-one low bits. A design that used the full byte, or strict comparisons, would then miscount and draw the wrong mask color. It drives frames whose total lands exactly on the threshold and one below it, which exposes an off-by-one compare. It also sends a one-pixel frame that carries start and end together, and idle cycles whose data would match. A counter that dropped the last pixel, did not reset at the first pixel, or counted idle cycles would latch a wrong total. A window with lo above hi must yield a zero count.

// File: rtl/colseg_pkg.sv
package colseg_pkg;

    localparam int CH_W   = 8;
    localparam int NIB_W  = 4;
    localparam int NUM_CH = 3;
    localparam int PIX_W  = CH_W * NUM_CH;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [NIB_W-1:0] lo;
        logic [NIB_W-1:0] hi;
    } nib_range_t;

    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
        logic eof;
    } vtime_t;

    typedef enum logic {
        VIEW_PASS = 1'b0,
        VIEW_MASK = 1'b1
    } view_e;

    function automatic logic [NIB_W-1:0] upper_nib(input logic [CH_W-1:0] c);
        return c[CH_W-1 -: NIB_W];
    endfunction

    function automatic logic nib_in_range(input logic [NIB_W-1:0] n, input nib_range_t w);
        return (n >= w.lo) && (n <= w.hi);
    endfunction

endpackage

// File: rtl/colseg_classify.sv
module colseg_classify
    import colseg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  rgb_t                    pix_i,
    input  vtime_t                  tm_i,
    input  nib_range_t [NUM_CH-1:0] win_i,
    output rgb_t                    pix_o,
    output vtime_t                  tm_o,
    output logic                    hit_o
);

    logic [NUM_CH-1:0][CH_W-1:0] chan;
    logic [NUM_CH-1:0]           ch_hit;

    // index 2 = red, 1 = green, 0 = blue
    assign chan = {pix_i.r, pix_i.g, pix_i.b};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_hit[c] = nib_in_range(upper_nib(chan[c]), win_i[c]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o <= '0;
            tm_o  <= '0;
            hit_o <= 1'b0;
        end else begin
            pix_o <= pix_i;
            tm_o  <= tm_i;
            hit_o <= &ch_hit;
        end
    end

endmodule

// File: rtl/colseg_view.sv
module colseg_view
    import colseg_pkg::*;
#(
    parameter logic [PIX_W-1:0] HILITE = 24'hFFFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  rgb_t             pix_i,
    input  vtime_t           tm_i,
    input  logic             hit_i,
    input  view_e            view_i,
    output logic [PIX_W-1:0] pix_o,
    output vtime_t           tm_o
);

    logic [PIX_W-1:0] shown;

    always_comb begin
        unique case (view_i)
            VIEW_MASK: shown = hit_i ? HILITE : '0;
            default:   shown = pix_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o <= '0;
            tm_o  <= '0;
        end else begin
            pix_o <= shown;
            tm_o  <= tm_i;
        end
    end

endmodule

// File: rtl/colseg_tally.sv
module colseg_tally #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             done_o
);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] total;

    always_comb begin
        base  = sof_i ? '0 : run_cnt;
        total = (hit_i && (base != '1)) ? base + 1'b1 : base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            count_o <= '0;
            flag_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (valid_i) begin
                run_cnt <= total;
                if (eof_i) begin
                    count_o <= total;
                    flag_o  <= (total >= thr_i);
                    done_o  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/colseg_detect.sv
module colseg_detect
    import colseg_pkg::*;
#(
    parameter int               MAX_COLS = 1600,
    parameter int               MAX_ROWS = 1200,
    parameter logic [23:0]      HILITE   = 24'hFFFFFF,
    localparam int              CNT_W    = $clog2(MAX_COLS * MAX_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic             in_eof,
    input  logic [23:0]      in_rgb,
    input  logic             mask_view,
    input  logic [3:0]       r_lo,
    input  logic [3:0]       r_hi,
    input  logic [3:0]       g_lo,
    input  logic [3:0]       g_hi,
    input  logic [3:0]       b_lo,
    input  logic [3:0]       b_hi,
    input  logic [CNT_W-1:0] threshold,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eol,
    output logic             out_eof,
    output logic [23:0]      out_rgb,
    output logic             det_flag,
    output logic [CNT_W-1:0] det_count,
    output logic             det_done
);

    rgb_t                    in_pix;
    vtime_t                  in_tm;
    nib_range_t [NUM_CH-1:0] win;
    rgb_t                    s1_pix;
    vtime_t                  s1_tm;
    logic                    s1_hit;
    vtime_t                  s2_tm;
    view_e                   view_sel;

    assign in_pix   = rgb_t'(in_rgb);
    assign in_tm    = '{valid: in_valid, sof: in_sof, eol: in_eol, eof: in_eof};
    assign win      = {nib_range_t'({r_lo, r_hi}),
                       nib_range_t'({g_lo, g_hi}),
                       nib_range_t'({b_lo, b_hi})};
    assign view_sel = mask_view ? VIEW_MASK : VIEW_PASS;

    colseg_classify u_classify (
        .clk   (clk),
        .rst   (rst),
        .pix_i (in_pix),
        .tm_i  (in_tm),
        .win_i (win),
        .pix_o (s1_pix),
        .tm_o  (s1_tm),
        .hit_o (s1_hit)
    );

    colseg_view #(.HILITE(HILITE)) u_view (
        .clk    (clk),
        .rst    (rst),
        .pix_i  (s1_pix),
        .tm_i   (s1_tm),
        .hit_i  (s1_hit),
        .view_i (view_sel),
        .pix_o  (out_rgb),
        .tm_o   (s2_tm)
    );

    colseg_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .valid_i (s1_tm.valid),
        .sof_i   (s1_tm.sof),
        .eof_i   (s1_tm.eof),
        .hit_i   (s1_hit),
        .thr_i   (threshold),
        .count_o (det_count),
        .flag_o  (det_flag),
        .done_o  (det_done)
    );

    assign out_valid = s2_tm.valid;
    assign out_sof   = s2_tm.sof;
    assign out_eol   = s2_tm.eol;
    assign out_eof   = s2_tm.eof;

endmodule

// File: rtl/colseg_detect_chk.sv
module colseg_detect_chk #(
    parameter int          MAX_COLS = 1600,
    parameter int          MAX_ROWS = 1200,
    parameter logic [23:0] HILITE   = 24'hFFFFFF,
    localparam int         CNT_W    = $clog2(MAX_COLS * MAX_ROWS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             mask_view,
    input logic             out_valid,
    input logic             out_eof,
    input logic [23:0]      out_rgb,
    input logic             det_flag,
    input logic [CNT_W-1:0] det_count,
    input logic             det_done
);

    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7
    done_align_chk: assert property (@(posedge clk) disable iff (rst)
        det_done |-> (out_eof && out_valid));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd1) && !det_done) |-> ($stable(det_flag) && $stable(det_count)));

    // R4
    mask_color_chk: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd1) && $past(mask_view) && out_valid) |-> ((out_rgb == 24'h0) || (out_rgb == HILITE)));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        det_done |-> (int'(det_count) <= MAX_COLS * MAX_ROWS));

endmodule

bind colseg_detect colseg_detect_chk #(
    .MAX_COLS (MAX_COLS),
    .MAX_ROWS (MAX_ROWS),
    .HILITE   (HILITE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mask_view (mask_view),
    .out_valid (out_valid),
    .out_eof   (out_eof),
    .out_rgb   (out_rgb),
    .det_flag  (det_flag),
    .det_count (det_count),
    .det_done  (det_done)
);

// File: tb/colseg_detect_tb.sv
`timescale 1ns/1ps
module colseg_detect_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, in_sof = 0, in_eol = 0, in_eof = 0;
    logic [23:0] in_rgb = '0;
    logic        mask_view = 0;
    logic [3:0]  r_lo = 0, r_hi = 0, g_lo = 0, g_hi = 0, b_lo = 0, b_hi = 0;
    logic [20:0] threshold = '0;
    logic        out_valid, out_sof, out_eol, out_eof;
    logic [23:0] out_rgb;
    logic        det_flag, det_done;
    logic [20:0] det_count;

    always #2 clk = ~clk;

    colseg_detect u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
        .in_rgb(in_rgb), .mask_view(mask_view),
        .r_lo(r_lo), .r_hi(r_hi), .g_lo(g_lo), .g_hi(g_hi), .b_lo(b_lo), .b_hi(b_hi),
        .threshold(threshold),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_eof(out_eof),
        .out_rgb(out_rgb), .det_flag(det_flag), .det_count(det_count), .det_done(det_done)
    );

    typedef struct {
        logic [23:0] rgb;
        logic        sof, eol, eof;
    } exp_t;

    exp_t   exp_q[$];
    string  tag_q[$];
    int     cnt_q[$];
    bit     flg_q[$];
    int     tests = 0;
    int     fails = 0;
    int     frame_hits;
    bit     finished = 0;
    logic [23:0] lst[8];
    logic        prev_flag;
    logic [20:0] prev_count;

    function automatic bit is_hit(input logic [23:0] p);
        return (p[23:20] >= r_lo) && (p[23:20] <= r_hi) &&
               (p[15:12] >= g_lo) && (p[15:12] <= g_hi) &&
               (p[7:4]   >= b_lo) && (p[7:4]   <= b_hi);
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic l, input logic e, input logic [23:0] p);
        @(posedge clk); #1;
        in_valid = v; in_sof = s; in_eol = l; in_eof = e; in_rgb = p;
    endtask

    // pushes the expectation for one valid pixel and drives it
    task automatic push_pix(input logic [23:0] p, input bit s, input bit l, input bit e, input string tag);
        exp_t x;
        bit   h;
        h = is_hit(p);
        if (s) frame_hits = 0;
        if (h) frame_hits++;
        x.rgb = mask_view ? (h ? 24'hFFFFFF : 24'h0) : p;
        x.sof = s; x.eol = l; x.eof = e;
        exp_q.push_back(x);
        tag_q.push_back(tag);
        if (e) begin
            cnt_q.push_back(frame_hits);
            flg_q.push_back(frame_hits >= int'(threshold));
        end
        drive(1'b1, s, l, e, p);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 24'h777777);
    endtask

    task automatic run_frame(input int cols, input int rows, input int seed, input int gap, input string tag);
        int idx = 0;
        for (int y = 0; y < rows; y++) begin
            for (int x = 0; x < cols; x++) begin
                logic [23:0] p;
                if (gap != 0 && (idx % gap) == gap - 1)
                    // R6: idle cycle carrying data that lies inside the window
                    drive(1'b0, 1'b0, 1'b0, 1'b0, {r_lo, 4'h0, g_lo, 4'h0, b_lo, 4'h0});
                p = {8'(idx * 37 + seed), 8'(idx * 91 + 5), 8'(idx * 13 + seed * 3)};
                push_pix(p, idx == 0, x == cols - 1, (x == cols - 1) && (y == rows - 1), tag);
                idx++;
            end
        end
        idle(6);
    endtask

    task automatic run_list(input string tag);
        for (int i = 0; i < 8; i++)
            push_pix(lst[i], i == 0, i == 3 || i == 7, i == 7, tag);
        idle(6);
    endtask

    task automatic check_hold(input string tag);
        int expc = cnt_q.size() == 0 ? int'(prev_count) : -1;
        check(det_done == 1'b0 && det_count == prev_count && det_flag == prev_flag,
              tag, "result hold while idle", int'(det_count), expc);
    endtask

    // monitor: compares output stream and frame results against queues
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t  x;
                    string t;
                    x = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_rgb == x.rgb, t, "out_rgb", int'(out_rgb), int'(x.rgb));
                    check({out_sof, out_eol, out_eof} == {x.sof, x.eol, x.eof}, "R5",
                          "sof/eol/eof", int'({out_sof, out_eol, out_eof}), int'({x.sof, x.eol, x.eof}));
                end
            end
            if (det_done) begin
                if (cnt_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected det_done", 1, 0);
                end else begin
                    int c;
                    bit f;
                    c = cnt_q.pop_front();
                    f = flg_q.pop_front();
                    check(int'(det_count) == c, "R7", "det_count", int'(det_count), c);
                    check(det_flag == f, "R7", "det_flag", int'(det_flag), int'(f));
                    check(out_eof == 1'b1, "R7", "done aligned with out_eof", int'(out_eof), 1);
                end
            end else if (det_count !== prev_count || det_flag !== prev_flag) begin
                check(1'b0, "R8", "result changed without done", int'(det_count), int'(prev_count));
            end
            prev_count = det_count;
            prev_flag  = det_flag;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        prev_count = '0;
        prev_flag  = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(out_valid == 0 && det_done == 0 && det_flag == 0 && det_count == 0,
              "R9", "reset outputs", int'({out_valid, det_done, det_flag, det_count}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        idle(3);

        // R3: pass view, mixed pixels
        r_lo = 4'h4; r_hi = 4'hB; g_lo = 4'h2; g_hi = 4'hD; b_lo = 4'h0; b_hi = 4'h9;
        threshold = 21'd1; mask_view = 1'b0;
        run_frame(8, 4, 3, 0, "R3");
        @(negedge clk); check_hold("R8");

        // R4 / R6: mask view with idle gaps, threshold too high to detect
        mask_view = 1'b1; threshold = 21'd1000;
        run_frame(8, 4, 11, 3, "R4");
        @(negedge clk); check_hold("R8");

        // R1 / R2: nibbles at the window edges, low bits 0 and F
        r_lo = 4'h5; r_hi = 4'hA; g_lo = 4'h5; g_hi = 4'hA; b_lo = 4'h5; b_hi = 4'hA;
        lst[0] = 24'h505050; lst[1] = 24'hAFAFAF; lst[2] = 24'h4F5555; lst[3] = 24'hB05555;
        lst[4] = 24'h554F55; lst[5] = 24'h5555B0; lst[6] = 24'h5FAF50; lst[7] = 24'h707070;
        threshold = 21'd4;   // R7: total equals threshold -> detected
        run_list("R2");
        threshold = 21'd5;   // R7: total one below threshold -> not detected
        run_list("R1");
        mask_view = 1'b0;
        run_list("R3");

        // R7: one-pixel frame, start and end on the same pixel
        threshold = 21'd1; mask_view = 1'b1;
        push_pix(24'h606060, 1, 1, 1, "R7");
        idle(6);

        // R2: empty window (lo > hi) matches nothing; threshold 0 still detects
        r_lo = 4'h9; r_hi = 4'h3; g_lo = 4'h0; g_hi = 4'hF; b_lo = 4'h0; b_hi = 4'hF;
        threshold = 21'd0;
        run_frame(6, 3, 5, 4, "R2");
        @(negedge clk); check_hold("R8");

        // R6: start a frame right after the previous one in pass view
        r_lo = 4'h0; r_hi = 4'hF;
        threshold = 21'd20; mask_view = 1'b0;
        run_frame(5, 4, 7, 0, "R6");

        idle(8);
        check(exp_q.size() == 0 && cnt_q.size() == 0, "R5", "all outputs seen",
              exp_q.size() + cnt_q.size(), 0);
        finish_run();
    end

endmodule